// File: doc/BRIEF.md
# Task and Event Channel Router with Interrupt Combiner

This block is a register slice that sits between a peripheral and a chip-wide channel bus of single-cycle pulses. Each of the peripheral's two task inputs (start and stop) can listen to one bus channel. When a pulse arrives on that channel and listening is switched on, the block hands the peripheral a one-cycle task strobe. Each of the peripheral's two events (completion and error) is latched in an event flag. When a flag turns on, the block can drive a single pulse onto a channel chosen by software.

The same slice owns the interrupt enables for the two events and merges the flags that are enabled into one level-sensitive interrupt line. Software reaches everything through a simple word-wide register port. Reads are combinational from the address. A write takes effect at the next clock edge.

Top module: `evt_chan_link`

## Requirements
- R1: After reset every routing register, event flag and interrupt enable reads 0, and `taskOut`, `chanOut` and `irq` are all low.
- R2: The start-task listen register is at offset 0x080 and the stop-task listen register is at 0x084. Each holds the channel number in bits [7:0] and the on/off flag in bit 31. Other bits ignore writes and read 0.
- R3: While a task's listen flag is set, a one-cycle pulse on its chosen channel produces exactly one high cycle on that task's bit of `taskOut` (bit 0 start, bit 1 stop), on the clock after the pulse. Pulses in consecutive cycles give consecutive strobes.
- R4: While a task's listen flag is clear, pulses on its channel leave its `taskOut` bit low.
- R5: The completion-event publish register is at 0x180 and the error-event publish register is at 0x184, using the same layout as R2.
- R6: When an event flag goes from 0 to 1 and its publish flag is set, `chanOut` carries exactly one high cycle on the chosen channel, in the first cycle the flag reads 1. A flag that is already set, or a publish flag that is clear, gives no pulse.
- R7: The completion flag (offset 0x100) and the error flag (offset 0x104) sit in bit 0. A pulse on `evtIn[0]` or `evtIn[1]` sets the flag. A register write stores bit 0 of the data. If a hardware set and a software write land in the same cycle, the hardware set wins.
- R8: Writing 1 to bits of the set alias at 0x304 turns on the interrupt enables: bit 0 for completion, bit 1 for error. Zero bits and reserved bits have no effect.
- R9: Writing 1 to bits of the clear alias at 0x308 turns the matching enables off, and zero bits have no effect. Reading either alias returns the current enables. Unmapped offsets read 0.
- R10: `irq` is high whenever some event flag and its enable are both 1, and it stays high until software clears the flag or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| chanIn | input | 256 | Incoming channel bus, one pulse bit per channel |
| chanOut | output | 256 | Outgoing channel bus driven by published events |
| evtIn | input | 2 | Event pulses from the peripheral (0 completion, 1 error) |
| taskOut | output | 2 | Task strobes to the peripheral (0 start, 1 stop) |
| irq | output | 1 | Combined interrupt |

## Verification
The in-line assertions check on every cycle that routing registers and enables change only after a matching write, that a task strobe never appears without its listen flag or without bus activity a cycle earlier, that a channel pulse out always follows an event input or a flag write, and that the interrupt only falls after a software write. Only the bench scenarios can show the actual values: register layouts and reserved-bit masking, the channel number a pulse lands on, the one-cycle latency of task strobes, the absence of a repeat pulse for an already-set flag, and the hardware-over-software priority on an event flag.

// File: rtl/evt_chan_link_pkg.sv
package evt_chan_link_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned NUM_TASKS  = 2;
  localparam int unsigned NUM_EVENTS = 2;
  localparam int unsigned MAX_UNITS  = (NUM_TASKS > NUM_EVENTS) ? NUM_TASKS : NUM_EVENTS;
  localparam int unsigned SEL_W      = (MAX_UNITS > 1) ? $clog2(MAX_UNITS) : 1;

  localparam logic [ADDR_W-1:0] OFS_LISTEN  = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_FLAG    = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_PUBLISH = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h308;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LISTEN,
    RD_PUBLISH,
    RD_FLAG,
    RD_ENABLE
  } rdKind_e;

  typedef struct packed {
    logic [NUM_TASKS-1:0]  listenWr;
    logic [NUM_EVENTS-1:0] publishWr;
    logic [NUM_EVENTS-1:0] flagWr;
    logic                  enSet;
    logic                  enClr;
    rdKind_e               rdKind;
    logic [SEL_W-1:0]      rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/evt_chan_link_ctrl.sv
module evt_chan_link_ctrl
  import evt_chan_link_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        strb
);

  logic [NUM_TASKS-1:0]  hitListen;
  logic [NUM_EVENTS-1:0] hitPublish;
  logic [NUM_EVENTS-1:0] hitFlag;
  logic                  hitEnSet;
  logic                  hitEnClr;

  genvar gt, ge;
  generate
    for (gt = 0; gt < NUM_TASKS; gt++) begin : g_task_dec
      assign hitListen[gt] = (regAddr == OFS_LISTEN + ADDR_W'(4 * gt));
    end
    for (ge = 0; ge < NUM_EVENTS; ge++) begin : g_evt_dec
      assign hitPublish[ge] = (regAddr == OFS_PUBLISH + ADDR_W'(4 * ge));
      assign hitFlag[ge]    = (regAddr == OFS_FLAG + ADDR_W'(4 * ge));
    end
  endgenerate

  assign hitEnSet = (regAddr == OFS_EN_SET);
  assign hitEnClr = (regAddr == OFS_EN_CLR);

  always_comb begin
    strb           = '0;
    strb.rdKind    = RD_NONE;
    strb.listenWr  = hitListen & {NUM_TASKS{regWrEn}};
    strb.publishWr = hitPublish & {NUM_EVENTS{regWrEn}};
    strb.flagWr    = hitFlag & {NUM_EVENTS{regWrEn}};
    strb.enSet     = hitEnSet & regWrEn;
    strb.enClr     = hitEnClr & regWrEn;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (hitListen[i]) begin
        strb.rdKind = RD_LISTEN;
        strb.rdSel  = SEL_W'(i);
      end
    end
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (hitPublish[i]) begin
        strb.rdKind = RD_PUBLISH;
        strb.rdSel  = SEL_W'(i);
      end
      if (hitFlag[i]) begin
        strb.rdKind = RD_FLAG;
        strb.rdSel  = SEL_W'(i);
      end
    end
    if (hitEnSet || hitEnClr) strb.rdKind = RD_ENABLE;
  end

  // R2 R5 R7 R8 R9: the decoded offsets are distinct, so at most one write target per cycle
  always_comb begin
    a_r9_one_write_target: assert ($onehot0({strb.listenWr, strb.publishWr, strb.flagWr,
                                             strb.enSet, strb.enClr}));
  end

endmodule

// File: rtl/evt_chan_link_dp.sv
module evt_chan_link_dp
  import evt_chan_link_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 256,
  parameter int unsigned IDX_W    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strb,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_CHAN-1:0]   chanIn,
  output logic [NUM_CHAN-1:0]   chanOut,
  input  logic [NUM_EVENTS-1:0] evtIn,
  output logic [NUM_TASKS-1:0]  taskOut,
  output logic                  irq
);

  localparam int unsigned EN_BIT = DATA_W - 1;

  logic [NUM_TASKS-1:0][IDX_W-1:0]  listenIdx;
  logic [NUM_TASKS-1:0]             listenOn;
  logic [NUM_EVENTS-1:0][IDX_W-1:0] publishIdx;
  logic [NUM_EVENTS-1:0]            publishOn;
  logic [NUM_EVENTS-1:0]            evtFlag;
  logic [NUM_EVENTS-1:0]            evtFlagPrev;
  logic [NUM_EVENTS-1:0]            intEn;
  logic [NUM_EVENTS-1:0]            pubFire;
  logic                             unusedWrBits;

  assign unusedWrBits = ^regWrData[EN_BIT-1:IDX_W];

  genvar gt, ge;
  generate
    for (gt = 0; gt < NUM_TASKS; gt++) begin : g_task
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          listenIdx[gt] <= '0;
          listenOn[gt]  <= 1'b0;
          taskOut[gt]   <= 1'b0;
        end else begin
          if (strb.listenWr[gt]) begin
            listenIdx[gt] <= regWrData[IDX_W-1:0];
            listenOn[gt]  <= regWrData[EN_BIT];
          end
          taskOut[gt] <= listenOn[gt] & chanIn[listenIdx[gt]];
        end
      end

      // R2: listen configuration only moves after a write to its own register
      a_r2_listen_by_write: assert property (@(posedge clk) disable iff (!rstN)
        (!$stable(listenIdx[gt]) || !$stable(listenOn[gt])) |-> $past(strb.listenWr[gt]));
      // R4: a task strobe needs the listen flag in the previous cycle
      a_r4_task_needs_on: assert property (@(posedge clk) disable iff (!rstN)
        taskOut[gt] |-> $past(listenOn[gt]));
      // R3: a task strobe needs bus activity in the previous cycle
      a_r3_task_after_pulse: assert property (@(posedge clk) disable iff (!rstN)
        taskOut[gt] |-> $past(|chanIn));
    end

    for (ge = 0; ge < NUM_EVENTS; ge++) begin : g_evt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          publishIdx[ge]  <= '0;
          publishOn[ge]   <= 1'b0;
          evtFlag[ge]     <= 1'b0;
          evtFlagPrev[ge] <= 1'b0;
        end else begin
          if (strb.publishWr[ge]) begin
            publishIdx[ge] <= regWrData[IDX_W-1:0];
            publishOn[ge]  <= regWrData[EN_BIT];
          end
          if (evtIn[ge])             evtFlag[ge] <= 1'b1;
          else if (strb.flagWr[ge])  evtFlag[ge] <= regWrData[0];
          evtFlagPrev[ge] <= evtFlag[ge];
        end
      end

      assign pubFire[ge] = evtFlag[ge] & ~evtFlagPrev[ge] & publishOn[ge];

      // R6: a publish fires only in the first cycle of a set flag
      a_r6_pub_single: assert property (@(posedge clk) disable iff (!rstN)
        (evtFlag[ge] && $past(evtFlag[ge])) |-> !pubFire[ge]);
      // R7: a flag rises only from a hardware pulse or a software write
      a_r7_flag_source: assert property (@(posedge clk) disable iff (!rstN)
        $rose(evtFlag[ge]) |-> $past(evtIn[ge] || strb.flagWr[ge]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= '0;
    end else begin
      intEn <= (intEn | (strb.enSet ? regWrData[NUM_EVENTS-1:0] : '0))
             & ~(strb.enClr ? regWrData[NUM_EVENTS-1:0] : '0);
    end
  end

  always_comb begin
    chanOut = '0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (pubFire[i]) chanOut[publishIdx[i]] = 1'b1;
    end
  end

  assign irq = |(evtFlag & intEn);

  always_comb begin
    regRdData = '0;
    unique case (strb.rdKind)
      RD_LISTEN: begin
        regRdData[IDX_W-1:0] = listenIdx[strb.rdSel];
        regRdData[EN_BIT]    = listenOn[strb.rdSel];
      end
      RD_PUBLISH: begin
        regRdData[IDX_W-1:0] = publishIdx[strb.rdSel];
        regRdData[EN_BIT]    = publishOn[strb.rdSel];
      end
      RD_FLAG:   regRdData[0] = evtFlag[strb.rdSel];
      RD_ENABLE: regRdData[NUM_EVENTS-1:0] = intEn;
      default:   regRdData = '0;
    endcase
  end

  // R8 R9: enables only change after a write to one of the aliases
  a_r8_enable_by_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(intEn) |-> $past(strb.enSet || strb.enClr));
  // R10: the interrupt only drops after a software write
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past((|strb.flagWr) || strb.enClr));
  // R6: outgoing bus activity needs an event pulse or a flag write a cycle earlier
  a_r6_pub_cause: assert property (@(posedge clk) disable iff (!rstN)
    (|chanOut) |-> $past((|evtIn) || (|strb.flagWr)));

endmodule

// File: rtl/evt_chan_link.sv
module evt_chan_link
  import evt_chan_link_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_CHAN-1:0]   chanIn,
  output logic [NUM_CHAN-1:0]   chanOut,
  input  logic [NUM_EVENTS-1:0] evtIn,
  output logic [NUM_TASKS-1:0]  taskOut,
  output logic                  irq
);

  localparam int unsigned IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  ctlStrobe_t strb;

  evt_chan_link_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  evt_chan_link_dp #(
    .NUM_CHAN (NUM_CHAN),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .chanIn    (chanIn),
    .chanOut   (chanOut),
    .evtIn     (evtIn),
    .taskOut   (taskOut),
    .irq       (irq)
  );

endmodule

// File: tb/evt_chan_link_bench.sv
module evt_chan_link_bench;
  import evt_chan_link_pkg::*;

  localparam int NCH = 256;
  localparam int SRC_RD = 0, SRC_TASK = 1, SRC_CH = 2, SRC_IRQ = 3, SRC_POP = 4;

  typedef struct {
    int          when;
    int          src;
    int          ch;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [NCH-1:0]    chanIn = '0;
  logic [NCH-1:0]    chanOut;
  logic [1:0]        evtIn = '0;
  logic [1:0]        taskOut;
  logic              irq;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFail = 0;
  bit    done = 0;
  item_t sb[$];
  item_t it;
  logic [31:0] act;

  evt_chan_link u_evt_chan_link (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .chanIn(chanIn),
    .chanOut(chanOut), .evtIn(evtIn), .taskOut(taskOut), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations at their due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].when <= cyc) begin
      it = sb.pop_front();
      case (it.src)
        SRC_RD:   act = regRdData;
        SRC_TASK: act = {30'd0, taskOut};
        SRC_CH:   act = {31'd0, chanOut[it.ch]};
        SRC_IRQ:  act = {31'd0, irq};
        default:  act = $countones(chanOut);
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s src=%0d actual=%h expected=%h at cycle %0d",
                 it.req, it.src, act, it.exp, cyc);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(int d, int src, int ch, logic [31:0] e, string r);
    sb.push_back('{cyc + d, src, ch, e, r});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rdc(logic [11:0] a, logic [31:0] e, string r);
    regAddr = a;
    chk(0, SRC_RD, 0, e, r);
    step();
  endtask

  task automatic chanPulse(int a, int b, logic [1:0] e, string r);
    chanIn = '0;
    chanIn[a] = 1'b1;
    if (b >= 0) chanIn[b] = 1'b1;
    chk(1, SRC_TASK, 0, {30'd0, e}, r);
    chk(2, SRC_TASK, 0, 32'd0, r);
    step();
    chanIn = '0;
    step(); step();
  endtask

  task automatic evtPulse(int i, int ch, int pop, int irqE, string r);
    evtIn = '0;
    evtIn[i] = 1'b1;
    if (irqE >= 0) chk(1, SRC_IRQ, 0, irqE, r);
    if (ch >= 0) chk(1, SRC_CH, ch, 32'd1, r);
    chk(1, SRC_POP, 0, pop, r);
    chk(2, SRC_POP, 0, 32'd0, r);
    step();
    evtIn = '0;
    step(); step();
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1: reset state
    chk(0, SRC_TASK, 0, 32'd0, "R1");
    chk(0, SRC_POP, 0, 32'd0, "R1");
    chk(0, SRC_IRQ, 0, 32'd0, "R1");
    rdc(12'h080, 32'd0, "R1");
    rdc(12'h084, 32'd0, "R1");
    rdc(12'h180, 32'd0, "R1");
    rdc(12'h184, 32'd0, "R1");
    rdc(12'h100, 32'd0, "R1");
    rdc(12'h304, 32'd0, "R1");
    rdc(12'h308, 32'd0, "R1");

    // R2: layout and reserved bits of listen registers
    wr(12'h080, 32'hFFFF_FFFF);
    rdc(12'h080, 32'h8000_00FF, "R2");
    wr(12'h084, 32'h8000_0005);
    rdc(12'h084, 32'h8000_0005, "R2");

    // R3: subscribed tasks fire on their channel
    chanPulse(255, -1, 2'b01, "R3");
    chanPulse(5, -1, 2'b10, "R3");
    chanPulse(255, 5, 2'b11, "R3");
    chanPulse(254, -1, 2'b00, "R3");
    // R3: back-to-back pulses give one strobe each
    chanIn[255] = 1'b1;
    chk(1, SRC_TASK, 0, 32'd1, "R3");
    chk(2, SRC_TASK, 0, 32'd1, "R3");
    chk(3, SRC_TASK, 0, 32'd0, "R3");
    step(); step();
    chanIn = '0;
    step(); step();

    // R4: listen flag off blocks the task
    wr(12'h080, 32'h0000_00FF);
    rdc(12'h080, 32'h0000_00FF, "R4");
    chanPulse(255, -1, 2'b00, "R4");

    // R5: publish register layout
    wr(12'h180, 32'h8000_0010);
    wr(12'h184, 32'hFFFF_FFC8);
    rdc(12'h180, 32'h8000_0010, "R5");
    rdc(12'h184, 32'h8000_00C8, "R5");

    // R6: one publish pulse on rise, none while already set
    evtPulse(0, 16, 1, 0, "R6");
    rdc(12'h100, 32'd1, "R7");
    evtPulse(0, -1, 0, 0, "R6");

    // R6: publish disabled
    wr(12'h100, 32'd0);
    rdc(12'h100, 32'd0, "R7");
    wr(12'h180, 32'h0000_0010);
    evtPulse(0, -1, 0, 0, "R6");

    // R8/R9: enable aliases
    wr(12'h304, 32'h0000_0002);
    rdc(12'h304, 32'd2, "R8");
    rdc(12'h308, 32'd2, "R9");
    wr(12'h304, 32'h0000_0000);
    rdc(12'h304, 32'd2, "R8");

    // R10: error event with enable drives irq and holds it
    evtPulse(1, 200, 1, 1, "R10");
    chk(0, SRC_IRQ, 0, 32'd1, "R10");
    step();
    wr(12'h308, 32'd0);
    rdc(12'h308, 32'd2, "R9");
    chk(0, SRC_IRQ, 0, 32'd1, "R10");
    wr(12'h104, 32'd0);
    chk(0, SRC_IRQ, 0, 32'd0, "R10");
    step();
    wr(12'h304, 32'd1);
    chk(0, SRC_IRQ, 0, 32'd1, "R10");
    step();
    wr(12'h308, 32'd1);
    chk(0, SRC_IRQ, 0, 32'd0, "R9");
    rdc(12'h304, 32'd2, "R9");

    // R7: hardware set wins over a same-cycle software clear
    wr(12'h100, 32'd0);
    regWrEn = 1'b1; regAddr = 12'h100; regWrData = 32'd0; evtIn = 2'b01;
    step();
    regWrEn = 1'b0; evtIn = '0;
    rdc(12'h100, 32'd1, "R7");
    wr(12'h104, 32'd1);
    rdc(12'h104, 32'd1, "R7");

    // R8: reserved alias bits ignored; R9: unmapped offset reads 0
    wr(12'h308, 32'hFFFF_FFFF);
    wr(12'h304, 32'hFFFF_FFFC);
    rdc(12'h304, 32'd0, "R8");
    rdc(12'h200, 32'd0, "R9");

    repeat (4) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule